// File: doc/BRIEF.md
# Configuration Manager Mode Sequencer

This block sits between a host and a programmable-logic fabric and walks the fabric through its configuration phases. The host reaches it through a small 32-bit register port: a status word reports the current phase and the strapped mode-select pins, and a control word holds the enable, chip-enable, reset-pull, bus-width, clock-to-data ratio and data-window controls. The phase advances from power-off through reset, configuration and initialisation to user mode only as the controls are written in the fixed order and the fabric handshakes arrive.

Configuration data enters through a separate 32-bit write port. Whole-word writes made in the configuration phase with the data window open are passed to the fabric one cycle later. Any other write is dropped and raises a sticky error bit in the status word, unless the block is disabled, in which case the write is ignored silently. The trailing configuration clock pulses and the fabric's done handshake are plain input pins here.

Top module: `cfgm_seq`

## Requirements
- R1: After reset the status word shows mode 0 with no error, the control word reads 0x002 (only the active-low chip enable bit set), fab_nconfig and fab_nce are 1 and fab_data_valid is 0.
- R2: The status word at byte offset 0x0 carries the mode in bits [2:0] (0 power-off, 1 reset, 2 configuration, 3 initialisation, 4 user), the mode-select pins in bits [7:3] and the sticky error flag in bit 8; other bits read 0.
- R3: The control word at byte offset 0x4 keeps enable (bit 0), active-low chip enable (bit 1), reset pull (bit 2), ratio (bits [7:6]), data window enable (bit 8) and 32-bit width (bit 9); other bits read 0. fab_nce follows bit 1 and cfg_width32 follows bit 9.
- R4: cfg_ratio_clks shows 1, 2, 4 or 8 for ratio codes 0, 1, 2 and 3.
- R5: With enable clear the mode becomes 0 one cycle later from any mode, and data-port writes are ignored: no forward and no error.
- R6: With enable set, setting reset pull moves the mode to 1 and drives fab_nconfig low.
- R7: Clearing reset pull while in mode 1 moves the mode to 2.
- R8: In mode 2 with the data window enabled, a data write with all four byte strobes set appears on fab_data with fab_data_valid high for exactly one cycle, one cycle after the write.
- R9: With enable set, a data write outside mode 2, with the window clear, or with any strobe clear is dropped and sets status bit 8; writing 1 to status bit 8 clears it.
- R10: In mode 2, opening the data window and then clearing it moves the mode to 3.
- R11: Mode 3 moves to 4 only once 4 trailing pulses on dclk_pulse have been seen in mode 3 and fab_done is high; otherwise it stays in 3.
- R12: Setting reset pull while in user mode restarts the sequence at mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| msel_pins | input | 5 | Strapped mode-select pins |
| fab_done | input | 1 | Fabric done handshake |
| dclk_pulse | input | 1 | One-cycle flag per trailing configuration clock |
| data_wr | input | 1 | Data-port write strobe |
| data_be | input | 4 | Data-port byte strobes |
| data_wdata | input | 32 | Data-port write word |
| fab_data | output | 32 | Word forwarded to the fabric |
| fab_data_valid | output | 1 | fab_data holds a new word |
| fab_nconfig | output | 1 | Active-low fabric reset request |
| fab_nce | output | 1 | Active-low fabric chip enable |
| cfg_width32 | output | 1 | Configuration bus is 32 bits wide |
| cfg_ratio_clks | output | 4 | Clocks per data word |

## Verification
The assertions assume the register and data strobes are single-cycle and that dclk_pulse and fab_done change only between edges; the bench drives every input on the falling edge and holds each strobe for one cycle. They also take the mode-select pins as static, so the bench straps them once before reset. Mode checks are sampled two cycles after a control write, since the mode register reacts one cycle after the control register changes.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;

    localparam int WORD_W   = 32;
    localparam int BE_W     = WORD_W / 8;
    localparam int MSEL_W   = 5;
    localparam int MODE_W   = 3;

    localparam logic [3:0] STATUS_OFS = 4'h0;
    localparam logic [3:0] CTRL_OFS   = 4'h4;

    localparam int ERR_BIT   = 8;
    localparam int MSEL_LSB  = 3;
    localparam logic [WORD_W-1:0] CTRL_MASK  = 32'h0000_03C7;
    localparam logic [WORD_W-1:0] CTRL_RESET = 32'h0000_0002;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF    = 3'd0,
        MODE_RESET  = 3'd1,
        MODE_CONFIG = 3'd2,
        MODE_INIT   = 3'd3,
        MODE_USER   = 3'd4
    } cfg_mode_e;

    typedef struct packed {
        logic       width32;
        logic       win_en;
        logic [1:0] ratio;
        logic       pull;
        logic       nce;
        logic       en;
    } ctrl_t;

    function automatic ctrl_t word_to_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.en      = w[0];
        c.nce     = w[1];
        c.pull    = w[2];
        c.ratio   = w[7:6];
        c.win_en  = w[8];
        c.width32 = w[9];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w      = '0;
        w[0]   = c.en;
        w[1]   = c.nce;
        w[2]   = c.pull;
        w[7:6] = c.ratio;
        w[8]   = c.win_en;
        w[9]   = c.width32;
        return w;
    endfunction

    function automatic logic [3:0] ratio_clks(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/cfgm_regs.sv
module cfgm_regs
    import cfgm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    input  logic [MSEL_W-1:0]   msel_pins,
    input  cfg_mode_e           mode,
    input  logic                drop_err,
    output ctrl_t               ctrl,
    output logic                err_flag,
    output logic [WORD_W-1:0]   reg_rdata
);

    logic hit_status;
    logic hit_ctrl;
    logic err_clr;
    logic [WORD_W-1:0] status_word;

    assign hit_status = (reg_addr == ADDR_W'(STATUS_OFS));
    assign hit_ctrl   = (reg_addr == ADDR_W'(CTRL_OFS));
    assign err_clr    = reg_wr && hit_status && reg_wdata[ERR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= word_to_ctrl(CTRL_RESET);
        end else if (reg_wr && hit_ctrl) begin
            ctrl <= word_to_ctrl(reg_wdata & CTRL_MASK);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag <= 1'b0;
        end else if (drop_err) begin
            err_flag <= 1'b1;
        end else if (err_clr) begin
            err_flag <= 1'b0;
        end
    end

    always_comb begin
        status_word                            = '0;
        status_word[MODE_W-1:0]                = mode;
        status_word[MSEL_LSB+MSEL_W-1:MSEL_LSB] = msel_pins;
        status_word[ERR_BIT]                   = err_flag;
    end

    always_comb begin
        if (hit_status)    reg_rdata = status_word;
        else if (hit_ctrl) reg_rdata = ctrl_to_word(ctrl);
        else               reg_rdata = '0;
    end

    // R9: the error flag holds until a write-one-clear reaches it
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        err_flag && !err_clr |=> err_flag);

    // R9: no error appears without a dropped write
    assert_err_cause_R9: assert property (@(posedge clk) disable iff (rst)
        !err_flag && !drop_err |=> !err_flag);

endmodule

// File: rtl/cfgm_mode_fsm.sv
module cfgm_mode_fsm
    import cfgm_pkg::*;
#(
    parameter int TRAIL_PULSES = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  ctrl_t     ctrl,
    input  logic      fab_done,
    input  logic      dclk_pulse,
    output cfg_mode_e mode
);

    localparam int CNT_W = $clog2(TRAIL_PULSES + 1);

    cfg_mode_e        mode_nxt;
    logic             win_seen;
    logic [CNT_W-1:0] trail_cnt;
    logic             trail_full;

    assign trail_full = (trail_cnt == CNT_W'(TRAIL_PULSES));

    always_comb begin
        mode_nxt = mode;
        if (!ctrl.en) begin
            mode_nxt = MODE_OFF;
        end else if (ctrl.pull) begin
            mode_nxt = MODE_RESET;
        end else begin
            unique case (mode)
                MODE_OFF:    mode_nxt = MODE_OFF;
                MODE_RESET:  mode_nxt = MODE_CONFIG;
                MODE_CONFIG: mode_nxt = (win_seen && !ctrl.win_en) ? MODE_INIT : MODE_CONFIG;
                MODE_INIT:   mode_nxt = (trail_full && fab_done) ? MODE_USER : MODE_INIT;
                MODE_USER:   mode_nxt = MODE_USER;
                default:     mode_nxt = MODE_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode <= MODE_OFF;
        else     mode <= mode_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst || mode != MODE_CONFIG) win_seen <= 1'b0;
        else if (ctrl.win_en)           win_seen <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || mode != MODE_INIT)        trail_cnt <= '0;
        else if (dclk_pulse && !trail_full)  trail_cnt <= trail_cnt + 1'b1;
    end

    // R2: the mode field stays within the defined encodings
    assert_mode_legal_R2: assert property (@(posedge clk) disable iff (rst)
        mode inside {MODE_OFF, MODE_RESET, MODE_CONFIG, MODE_INIT, MODE_USER});

    // R5: disable forces power-off on the next edge
    assert_off_when_disabled_R5: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |=> mode == MODE_OFF);

    // R6: enabled reset pull forces reset on the next edge
    assert_pull_to_reset_R6: assert property (@(posedge clk) disable iff (rst)
        ctrl.en && ctrl.pull |=> mode == MODE_RESET);

    // R11: user mode is never reached while done is low
    assert_hold_init_R11: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_INIT && !fab_done |=> mode != MODE_USER);

    // R11: user mode is entered only from initialisation
    assert_user_from_init_R11: assert property (@(posedge clk) disable iff (rst)
        mode != MODE_INIT && mode != MODE_USER |=> mode != MODE_USER);

    // R10: initialisation is entered only from configuration
    assert_init_from_config_R10: assert property (@(posedge clk) disable iff (rst)
        mode != MODE_CONFIG && mode != MODE_INIT |=> mode != MODE_INIT);

endmodule

// File: rtl/cfgm_data_gate.sv
module cfgm_data_gate
    import cfgm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  cfg_mode_e         mode,
    input  logic              data_wr,
    input  logic [BE_W-1:0]   data_be,
    input  logic [WORD_W-1:0] data_wdata,
    output logic [WORD_W-1:0] fab_data,
    output logic              fab_data_valid,
    output logic              drop_err
);

    logic accept;

    assign accept   = data_wr && ctrl.en && ctrl.win_en &&
                      (mode == MODE_CONFIG) && (&data_be);
    assign drop_err = data_wr && ctrl.en && !accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            fab_data_valid <= 1'b0;
            fab_data       <= '0;
        end else begin
            fab_data_valid <= accept;
            if (accept) fab_data <= data_wdata;
        end
    end

    // R8: nothing is forwarded outside the configuration mode
    assert_fwd_only_config_R8: assert property (@(posedge clk) disable iff (rst)
        mode != MODE_CONFIG |=> !fab_data_valid);

    // R5: a disabled block forwards nothing and flags nothing
    assert_ignore_disabled_R5: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |-> !drop_err ##1 !fab_data_valid);

    // R9: partial-word writes are never forwarded
    assert_no_partial_R9: assert property (@(posedge clk) disable iff (rst)
        data_wr && !(&data_be) |=> !fab_data_valid);

endmodule

// File: rtl/cfgm_seq.sv
module cfgm_seq
    import cfgm_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int TRAIL_PULSES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [4:0]          msel_pins,
    input  logic                fab_done,
    input  logic                dclk_pulse,
    input  logic                data_wr,
    input  logic [3:0]          data_be,
    input  logic [31:0]         data_wdata,
    output logic [31:0]         fab_data,
    output logic                fab_data_valid,
    output logic                fab_nconfig,
    output logic                fab_nce,
    output logic                cfg_width32,
    output logic [3:0]          cfg_ratio_clks
);

    ctrl_t     ctrl;
    cfg_mode_e mode;
    logic      drop_err;
    logic      err_flag;

    cfgm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .msel_pins (msel_pins),
        .mode      (mode),
        .drop_err  (drop_err),
        .ctrl      (ctrl),
        .err_flag  (err_flag),
        .reg_rdata (reg_rdata)
    );

    cfgm_mode_fsm #(.TRAIL_PULSES(TRAIL_PULSES)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .fab_done   (fab_done),
        .dclk_pulse (dclk_pulse),
        .mode       (mode)
    );

    cfgm_data_gate u_gate (
        .clk            (clk),
        .rst            (rst),
        .ctrl           (ctrl),
        .mode           (mode),
        .data_wr        (data_wr),
        .data_be        (data_be),
        .data_wdata     (data_wdata),
        .fab_data       (fab_data),
        .fab_data_valid (fab_data_valid),
        .drop_err       (drop_err)
    );

    assign fab_nconfig    = ~(ctrl.en & ctrl.pull);
    assign fab_nce        = ctrl.nce;
    assign cfg_width32    = ctrl.width32;
    assign cfg_ratio_clks = ratio_clks(ctrl.ratio);

    // R6: the fabric reset request tracks the reset mode entry
    assert_nconfig_reset_R6: assert property (@(posedge clk) disable iff (rst)
        !fab_nconfig |=> mode == MODE_RESET);

    // R1: the error flag is visible only with a prior drop
    assert_err_has_cause_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> $past(drop_err));

endmodule

// File: tb/cfgm_seq_bench.sv
module cfgm_seq_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [4:0]  msel_pins;
    logic        fab_done;
    logic        dclk_pulse;
    logic        data_wr;
    logic [3:0]  data_be;
    logic [31:0] data_wdata;
    logic [31:0] fab_data;
    logic        fab_data_valid;
    logic        fab_nconfig;
    logic        fab_nce;
    logic        cfg_width32;
    logic [3:0]  cfg_ratio_clks;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    localparam logic [4:0]  MSEL = 5'h0A;
    localparam logic [31:0] ST_BASE = {24'd0, MSEL, 3'd0};

    always #5 clk = ~clk;

    cfgm_seq u_cfgm_seq (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msel_pins(msel_pins),
        .fab_done(fab_done), .dclk_pulse(dclk_pulse), .data_wr(data_wr),
        .data_be(data_be), .data_wdata(data_wdata), .fab_data(fab_data),
        .fab_data_valid(fab_data_valid), .fab_nconfig(fab_nconfig),
        .fab_nce(fab_nce), .cfg_width32(cfg_width32),
        .cfg_ratio_clks(cfg_ratio_clks)
    );

    // control write, expected readback, expected clocks per word, width, nce
    typedef struct packed {
        logic [31:0] wr;
        logic [31:0] rd;
        logic [3:0]  clks;
        logic        w32;
        logic        nce;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 32'h0000_0000, 4'd1, 1'b0, 1'b0},
        '{32'hFFFF_FFFE, 32'h0000_03C6, 4'd8, 1'b1, 1'b1},
        '{32'h0000_0040, 32'h0000_0040, 4'd2, 1'b0, 1'b0},
        '{32'h0000_0080, 32'h0000_0080, 4'd4, 1'b0, 1'b0},
        '{32'h0000_0202, 32'h0000_0202, 4'd1, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic data_write(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        data_wr = 1'b1; data_be = be; data_wdata = d;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        dclk_pulse = 1'b1;
        @(negedge clk);
        dclk_pulse = 1'b0;
    endtask

    task automatic check_mode(input string req, input logic [2:0] m);
        logic [31:0] v;
        reg_read(4'h0, v);
        check(req, {29'd0, v[2:0]}, {29'd0, m});
    endtask

    task automatic clear_err();
        reg_write(4'h0, 32'h0000_0100);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        msel_pins = MSEL; fab_done = 0; dclk_pulse = 0;
        data_wr = 0; data_be = 0; data_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R2: reset state and status layout
        reg_read(4'h0, v);  check("R1 R2 status", v, ST_BASE);
        reg_read(4'h4, v);  check("R1 ctrl", v, 32'h2);
        check("R1 nconfig", {31'd0, fab_nconfig}, 32'd1);
        check("R1 nce", {31'd0, fab_nce}, 32'd1);
        check("R1 valid", {31'd0, fab_data_valid}, 32'd0);
        reg_read(4'h8, v);  check("R2 unmapped", v, 32'd0);

        // R3 / R4: control field table
        for (int i = 0; i < NV; i++) begin
            reg_write(4'h4, VECS[i].wr);
            reg_read(4'h4, v);
            check("R3 readback", v, VECS[i].rd);
            check("R4 ratio", {28'd0, cfg_ratio_clks}, {28'd0, VECS[i].clks});
            check("R3 width", {31'd0, cfg_width32}, {31'd0, VECS[i].w32});
            check("R3 nce", {31'd0, fab_nce}, {31'd0, VECS[i].nce});
            check("R5 mode off", {31'd0, fab_nconfig}, 32'd1);
        end

        // R5: disabled data write ignored
        reg_write(4'h4, 32'h0);
        data_write(4'hF, 32'hDEAD_BEEF);
        check("R5 no fwd", {31'd0, fab_data_valid}, 32'd0);
        reg_read(4'h0, v); check("R5 no err", v, ST_BASE);

        // R9: enabled write in power-off is an error; W1C clears
        reg_write(4'h4, 32'h1);
        check_mode("R5 stays off", 3'd0);
        data_write(4'hF, 32'h1111_1111);
        @(negedge clk);
        reg_read(4'h0, v); check("R9 err set off", v, ST_BASE | 32'h100);
        clear_err();
        reg_read(4'h0, v); check("R9 err clear", v, ST_BASE);

        // R6 / R7
        reg_write(4'h4, 32'h5);
        check_mode("R6 reset", 3'd1);
        check("R6 nconfig low", {31'd0, fab_nconfig}, 32'd0);
        reg_write(4'h4, 32'h1);
        check_mode("R7 config", 3'd2);

        // R9: window closed in config
        data_write(4'hF, 32'h2222_2222);
        check("R9 no fwd closed", {31'd0, fab_data_valid}, 32'd0);
        @(negedge clk);
        reg_read(4'h0, v); check("R9 err window", v, ST_BASE | 32'h100 | 32'h2);
        clear_err();

        // R8: accepted word
        reg_write(4'h4, 32'h101);
        data_write(4'hF, 32'hA5C3_0F96);
        check("R8 valid", {31'd0, fab_data_valid}, 32'd1);
        check("R8 data", fab_data, 32'hA5C3_0F96);
        @(negedge clk);
        check("R8 valid one cycle", {31'd0, fab_data_valid}, 32'd0);
        reg_read(4'h0, v); check("R8 no err", v, ST_BASE | 32'h2);

        // R9: partial word
        data_write(4'h3, 32'h3333_3333);
        check("R9 partial no fwd", {31'd0, fab_data_valid}, 32'd0);
        @(negedge clk);
        reg_read(4'h0, v); check("R9 partial err", v[8], 1'b1);
        clear_err();

        // R10
        reg_write(4'h4, 32'h1);
        check_mode("R10 init", 3'd3);

        // R11: done low holds init
        for (int k = 0; k < 4; k++) pulse();
        repeat (3) @(negedge clk);
        check_mode("R11 hold done low", 3'd3);
        fab_done = 1'b1;
        repeat (2) @(negedge clk);
        check_mode("R11 user", 3'd4);

        // R9: write in user mode
        data_write(4'hF, 32'h4444_4444);
        @(negedge clk);
        reg_read(4'h0, v); check("R9 err user", v[8], 1'b1);
        clear_err();

        // R12: restart, then pulse count boundary
        reg_write(4'h4, 32'h5);
        check_mode("R12 restart", 3'd1);
        reg_write(4'h4, 32'h1);
        reg_write(4'h4, 32'h101);
        reg_write(4'h4, 32'h1);
        check_mode("R10 init again", 3'd3);
        for (int k = 0; k < 3; k++) pulse();
        repeat (2) @(negedge clk);
        check_mode("R11 three pulses", 3'd3);
        pulse();
        repeat (2) @(negedge clk);
        check_mode("R11 fourth pulse", 3'd4);

        // R5: disable from user
        reg_write(4'h4, 32'h0);
        check_mode("R5 off from user", 3'd0);

        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule